// File: doc/BRIEF.md
# Serial Receive Engine with Error Flagging

This block turns an asynchronous serial line into characters for a downstream receive FIFO. It builds its own 16x oversampling tick from the reference clock through an integer plus fractional divisor, synchronises the line, qualifies a start bit at mid-bit, and then recovers five to eight data bits (least significant first), an optional parity bit and one stop bit.

Each completed character is offered on a one-cycle push strobe, together with its data and with flags for framing, parity and break errors. An overrun flag reports a character that was lost because the FIFO signalled full. A line held low for a whole frame is reported as one zero character marked as a break, after which the engine waits for the line to go high again. A loop-back select takes the line from the local transmit output instead of the pin. The line-control inputs are expected to stay constant while a character is being received.

Top module: `uart_rx_engine`

## Requirements
- R1: `word_len` values 0, 1, 2, 3 select 5, 6, 7, 8 data bits. Bits are received least significant first, and the unused upper bits of `push_data` read 0.
- R2: With `par_en`=1 and `par_stick`=0, a parity bit follows the data. `par_even`=1 expects an even count of ones over data plus parity, and `par_even`=0 expects an odd count. A mismatch sets `err_parity`. With `par_en`=0 no parity bit is taken and `err_parity` stays 0.
- R3: With `par_en`=1 and `par_stick`=1, the expected parity bit is the inverse of `par_even`, whatever the data.
- R4: `err_frame` is set when the stop bit, sampled at mid-bit, is 0. Only one stop bit is examined.
- R5: If the line is low at every sample from the start bit to the stop bit, one push is made with `push_data`=0, `err_break`=1, `err_frame`=0 and `err_parity`=0.
- R6: After a break, no character is accepted while the line stays low. Reception resumes only after the line goes high and a new start bit arrives.
- R7: A character that completes while `fifo_full`=1 is not pushed, and `push_data` keeps its previous value. It sets `err_overrun`, which clears on the first clock edge at which `fifo_full` is 0.
- R8: Dropping `rx_en` during a character still completes and pushes that character. A frame that begins while `rx_en`=0 is ignored.
- R9: A low pulse that is gone by the mid-bit check (8 ticks after detection) is rejected, and nothing is pushed.
- R10: With `loop_sel`=1 the line is taken from `tx_loop`, and `rx_pin` has no effect.
- R11: Each `tick_16x` period lasts `div_int` reference clocks. A 6-bit accumulator adds `div_frac` at every tick, and each carry lengthens the next period by one clock, so 64 consecutive periods span 64*`div_int`+`div_frac` clocks.
- R12: A divisor with `div_int`=0, or with `div_int`=0xFFFF and a nonzero `div_frac`, is invalid and produces no ticks.
- R13: After reset, `push_valid`, all error flags and `tick_16x` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pin | input | 1 | Serial line from the pin |
| tx_loop | input | 1 | Local transmit output, used in loop-back |
| loop_sel | input | 1 | 1 selects `tx_loop` as the line |
| rx_en | input | 1 | Receive enable, checked before a new start bit |
| div_int | input | 16 | Integer part of the divisor |
| div_frac | input | 6 | Fractional part of the divisor, in 1/64 units |
| word_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Stick parity select |
| fifo_full | input | 1 | Downstream FIFO cannot accept a push |
| tick_16x | output | 1 | Oversampling tick, one clock wide |
| push_valid | output | 1 | One-cycle push strobe |
| push_data | output | 8 | Received character |
| err_frame | output | 1 | Framing error of the pushed character |
| err_parity | output | 1 | Parity error of the pushed character |
| err_break | output | 1 | Pushed character is a break |
| err_overrun | output | 1 | A character was lost while the FIFO was full |

## Verification
The main receive path is swept over every data value of every word length. Each frame rotates through four parity modes: none, even, odd and stick, with stick using both polarities. Every fifth parity frame carries a deliberately wrong parity bit. This separates bit-order faults from parity-polarity faults, and it separates stick parity from data-dependent parity. Directed frames then cover the following cases:
- a low stop bit, with non-zero data and again with zero data and a high parity bit, which tells framing errors apart from breaks;
- a line held low for three frames, which shows that exactly one break is pushed;
- a short glitch;
- a full FIFO;
- `rx_en` dropped part-way through a character and held low while idle;
- loop-back with the pin held low.

The tick period is measured over 64 periods for several integer and fractional pairs and compared against 64*`div_int`+`div_frac`. Invalid divisors are checked to give no ticks at all.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int OVS      = 16;
  localparam int OVS_W    = $clog2(OVS);
  localparam int DATA_MAX = 8;
  localparam int IDX_W    = $clog2(DATA_MAX);
  localparam int MIN_BITS = 5;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP,
    RX_BRK_WAIT
  } rx_state_e;

  typedef struct packed {
    logic [DATA_MAX-1:0] data;
    logic                frame_err;
    logic                parity_err;
    logic                break_err;
  } rx_char_t;
endpackage

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick
);
  logic [INT_W-1:0]  cnt_q, cnt_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic              tick_q, tick_d;
  logic              div_ok;
  logic [FRAC_W:0]   acc_sum;
  logic [INT_W:0]    reload;

  always_comb begin
    div_ok  = (div_int != '0) && !((div_int == {INT_W{1'b1}}) && (div_frac != '0));
    acc_sum = {1'b0, acc_q} + {1'b0, div_frac};
    reload  = {1'b0, div_int} - {{INT_W{1'b0}}, 1'b1} + {{INT_W{1'b0}}, acc_sum[FRAC_W]};
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    tick_d  = 1'b0;
    if (!div_ok) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (cnt_q == '0) begin
      tick_d = 1'b1;
      acc_d  = acc_sum[FRAC_W-1:0];
      cnt_d  = reload[INT_W-1:0];
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/rx_line_in.sv
module rx_line_in #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pin,
  input  logic tx_loop,
  input  logic loop_sel,
  output logic line
);
  logic                   raw;
  logic [SYNC_STAGES-1:0] sync_q, sync_d;

  assign raw = loop_sel ? tx_loop : rx_pin;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_comb sync_d = raw;
    end else begin : g_chain
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], raw};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end

  assign line = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic       rx_en,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  output logic       done,
  output rx_char_t   done_char
);
  localparam logic [OVS_W-1:0] T_HALF = OVS_W'(OVS/2 - 1);
  localparam logic [OVS_W-1:0] T_LAST = OVS_W'(OVS - 1);

  rx_state_e           state_q, state_d;
  logic [OVS_W-1:0]    tcnt_q, tcnt_d;
  logic [IDX_W-1:0]    bidx_q, bidx_d;
  logic [DATA_MAX-1:0] shreg_q, shreg_d;
  logic                pbit_q, pbit_d;
  logic                zero_q, zero_d;
  logic [IDX_W-1:0]    last_idx;
  logic                ones_odd, exp_par;

  always_comb begin
    last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(word_len);
    ones_odd = ^shreg_q;
    exp_par  = par_stick ? !par_even : (par_even ? ones_odd : !ones_odd);
  end

  always_comb begin
    state_d   = state_q;
    tcnt_d    = tcnt_q;
    bidx_d    = bidx_q;
    shreg_d   = shreg_q;
    pbit_d    = pbit_q;
    zero_d    = zero_q;
    done      = 1'b0;
    done_char = '0;
    case (state_q)
      RX_IDLE: begin
        if (tick && rx_en && !line) begin
          state_d = RX_START;
          tcnt_d  = '0;
        end
      end
      RX_START: begin
        if (tick) begin
          if (tcnt_q == T_HALF) begin
            if (line) begin
              state_d = RX_IDLE;
            end else begin
              state_d = RX_DATA;
              tcnt_d  = '0;
              bidx_d  = '0;
              shreg_d = '0;
              zero_d  = 1'b1;
            end
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (tick) begin
          if (tcnt_q == T_LAST) begin
            tcnt_d          = '0;
            shreg_d[bidx_q] = line;
            zero_d          = zero_q & !line;
            if (bidx_q == last_idx) state_d = par_en ? RX_PARITY : RX_STOP;
            else                    bidx_d  = bidx_q + 1'b1;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      RX_PARITY: begin
        if (tick) begin
          if (tcnt_q == T_LAST) begin
            tcnt_d  = '0;
            pbit_d  = line;
            zero_d  = zero_q & !line;
            state_d = RX_STOP;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      RX_STOP: begin
        if (tick) begin
          if (tcnt_q == T_LAST) begin
            done = 1'b1;
            if (!line && zero_q) begin
              done_char.break_err = 1'b1;
              state_d             = RX_BRK_WAIT;
            end else begin
              done_char.data       = shreg_q;
              done_char.frame_err  = !line;
              done_char.parity_err = par_en && (pbit_q != exp_par);
              state_d              = RX_IDLE;
            end
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      RX_BRK_WAIT: begin
        if (line) state_d = RX_IDLE;
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      shreg_q <= '0;
      pbit_q  <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bidx_q  <= bidx_d;
      shreg_q <= shreg_d;
      pbit_q  <= pbit_d;
      zero_q  <= zero_d;
    end
  end
endmodule

// File: rtl/rx_push_stage.sv
module rx_push_stage
  import uart_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done,
  input  rx_char_t            done_char,
  input  logic                fifo_full,
  output logic                push_valid,
  output logic [DATA_MAX-1:0] push_data,
  output logic                err_frame,
  output logic                err_parity,
  output logic                err_break,
  output logic                err_overrun
);
  logic     pv_q, pv_d;
  rx_char_t char_q, char_d;
  logic     ovr_q, ovr_d;

  always_comb begin
    pv_d   = done && !fifo_full;
    char_d = pv_d ? done_char : char_q;
    if (done && fifo_full) ovr_d = 1'b1;
    else if (!fifo_full)   ovr_d = 1'b0;
    else                   ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q   <= 1'b0;
      char_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      pv_q   <= pv_d;
      char_q <= char_d;
      ovr_q  <= ovr_d;
    end
  end

  assign push_valid  = pv_q;
  assign push_data   = char_q.data;
  assign err_frame   = char_q.frame_err;
  assign err_parity  = char_q.parity_err;
  assign err_break   = char_q.break_err;
  assign err_overrun = ovr_q;
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_rx_pkg::*;
#(
  parameter int INT_W       = 16,
  parameter int FRAC_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_pin,
  input  logic              tx_loop,
  input  logic              loop_sel,
  input  logic              rx_en,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic [1:0]        word_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  input  logic              fifo_full,
  output logic              tick_16x,
  output logic              push_valid,
  output logic [7:0]        push_data,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_break,
  output logic              err_overrun
);
  logic     line;
  logic     done;
  rx_char_t done_char;

  baud_tick_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_int(div_int), .div_frac(div_frac), .tick(tick_16x)
  );

  rx_line_in #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .tx_loop(tx_loop),
    .loop_sel(loop_sel), .line(line)
  );

  rx_frame_engine u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick_16x), .line(line), .rx_en(rx_en),
    .word_len(word_len), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .done(done), .done_char(done_char)
  );

  rx_push_stage u_push (
    .clk(clk), .rst_n(rst_n), .done(done), .done_char(done_char), .fifo_full(fifo_full),
    .push_valid(push_valid), .push_data(push_data), .err_frame(err_frame),
    .err_parity(err_parity), .err_break(err_break), .err_overrun(err_overrun)
  );
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fifo_full,
  input logic              push_valid,
  input logic [7:0]        push_data,
  input logic              err_frame,
  input logic              err_parity,
  input logic              err_break,
  input logic              err_overrun,
  input logic              tick_16x,
  input logic [INT_W-1:0]  div_int,
  input logic [FRAC_W-1:0] div_frac,
  input logic [1:0]        word_len,
  input logic              par_en
);
  assert_five_bit_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && word_len == 2'd0) |-> (push_data[7:5] == 3'b000));

  assert_no_parity_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !par_en) |-> !err_parity);

  assert_break_is_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && err_break) |-> (push_data == 8'h00 && !err_frame && !err_parity));

  assert_no_push_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> !$past(fifo_full));

  assert_overrun_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(fifo_full));

  assert_push_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |=> !push_valid);

  assert_no_tick_bad_div_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(div_int) == '0) |-> !tick_16x);
endmodule

bind uart_rx_engine uart_rx_checker #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_rx_chk (.*);

// File: tb/tb_uart_rx_engine.sv
module tb_uart_rx_engine;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 16;
  localparam int WDOG       = 195000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_pin = 1'b1, tx_loop = 1'b1, loop_sel = 1'b0, rx_en = 1'b1;
  logic [15:0] div_int = 16'd1;
  logic [5:0]  div_frac = 6'd0;
  logic [1:0]  word_len = 2'd3;
  logic        par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0, fifo_full = 1'b0;
  logic        tick_16x, push_valid, err_frame, err_parity, err_break, err_overrun;
  logic [7:0]  push_data;

  int checks = 0, fails = 0, cyc = 0, pushes = 0;
  logic [7:0] last_data = 8'h00;
  logic last_fe = 1'b0, last_pe = 1'b0, last_be = 1'b0;
  bit use_loop = 1'b0;

  uart_rx_engine dut (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .tx_loop(tx_loop), .loop_sel(loop_sel),
    .rx_en(rx_en), .div_int(div_int), .div_frac(div_frac), .word_len(word_len),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick), .fifo_full(fifo_full),
    .tick_16x(tick_16x), .push_valid(push_valid), .push_data(push_data),
    .err_frame(err_frame), .err_parity(err_parity), .err_break(err_break),
    .err_overrun(err_overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && push_valid) begin
      pushes    <= pushes + 1;
      last_data <= push_data;
      last_fe   <= err_frame;
      last_pe   <= err_parity;
      last_be   <= err_break;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive(input logic v, input int n);
    if (use_loop) tx_loop = v; else rx_pin = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                            input bit pb, input bit stop_ok);
    drive(1'b0, BIT_CLKS);
    for (int i = 0; i < nb; i++) drive(d[i], BIT_CLKS);
    if (pen) drive(pb, BIT_CLKS);
    if (stop_ok) drive(1'b1, BIT_CLKS);
    else begin
      drive(1'b0, 12);
      drive(1'b1, BIT_CLKS - 12);
    end
    drive(1'b1, BIT_CLKS);
  endtask

  function automatic bit exp_pbit(input int d, input int nb, input bit even, input bit stick);
    int ones = $countones(d & ((1 << nb) - 1));
    if (stick) return !even;
    return even ? bit'(ones % 2) : !bit'(ones % 2);
  endfunction

  task automatic measure_ticks(input int d, input int f);
    int t0, n, expv;
    div_int = 16'(d); div_frac = 6'(f);
    do_reset();
    while (!tick_16x) @(negedge clk);
    t0 = cyc; n = 0;
    while (n < 64) begin
      @(negedge clk);
      if (tick_16x) n++;
    end
    expv = 64 * d + f;
    chk((cyc - t0) == expv, "R11 tick span", cyc - t0, expv);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    summary();
    $finish;
  end

  initial begin
    int p0, nticks;
    do_reset();
    @(negedge clk);
    // R13 reset state (sampled before the first tick propagates to a push)
    chk(!push_valid && !err_frame && !err_parity && !err_break && !err_overrun,
        "R13 reset outputs", {push_valid, err_frame, err_parity, err_break, err_overrun}, 0);

    // R11 fractional divisor
    measure_ticks(1, 0);
    measure_ticks(3, 17);
    measure_ticks(5, 63);
    measure_ticks(2, 32);

    // R12 invalid divisors
    div_int = 16'd0; div_frac = 6'd5;
    do_reset();
    nticks = 0;
    repeat (300) begin @(negedge clk); if (tick_16x) nticks++; end
    chk(nticks == 0, "R12 div_int zero", nticks, 0);
    div_int = 16'hFFFF; div_frac = 6'd1;
    do_reset();
    nticks = 0;
    repeat (300) begin @(negedge clk); if (tick_16x) nticks++; end
    chk(nticks == 0, "R12 max int with fraction", nticks, 0);

    // Frame phase
    div_int = 16'd1; div_frac = 6'd0;
    do_reset();
    repeat (40) @(negedge clk);

    // R1 R2 R3 sweep
    for (int wl = 0; wl < 4; wl++) begin
      for (int d = 0; d < (1 << (5 + wl)); d++) begin
        int  m  = (d + wl) % 4;
        bit  pen = (m != 0);
        bit  stk = (m == 3);
        bit  evn = (m == 1) || (m == 3 && d[0]);
        bit  bad = pen && (d % 5 == 0);
        bit  pb  = exp_pbit(d, 5 + wl, evn, stk) ^ bad;
        word_len = 2'(wl); par_en = pen; par_even = evn; par_stick = stk;
        p0 = pushes;
        send_frame(8'(d), 5 + wl, pen, pb, 1'b1);
        chk(pushes == p0 + 1, "R1 one push per frame", pushes - p0, 1);
        chk(last_data == 8'(d), stk ? "R3 data stick mode" : "R1 data", last_data, d);
        chk(last_pe == bad, stk ? "R3 stick parity flag" : "R2 parity flag", last_pe, bad);
        chk(!last_fe && !last_be, "R4 no frame/break on good frame", {last_fe, last_be}, 0);
      end
    end

    // R4 framing error, non-zero data
    word_len = 2'd3; par_en = 1'b0; par_stick = 1'b0;
    p0 = pushes;
    send_frame(8'hA5, 8, 1'b0, 1'b0, 1'b0);
    chk(pushes == p0 + 1, "R4 push on bad stop", pushes - p0, 1);
    chk(last_fe && !last_be, "R4 frame flag set, no break", {last_fe, last_be}, 2);
    chk(last_data == 8'hA5, "R4 data kept", last_data, 8'hA5);

    // R4 zero data, stick parity bit high: framing, not break
    par_en = 1'b1; par_stick = 1'b1; par_even = 1'b0;
    send_frame(8'h00, 8, 1'b1, 1'b1, 1'b0);
    chk(last_fe && !last_be && !last_pe, "R4 zero data high parity is framing",
        {last_fe, last_be, last_pe}, 4);

    // R5 R6 break held for three frames
    par_stick = 1'b0; par_even = 1'b1;
    p0 = pushes;
    drive(1'b0, 3 * 12 * BIT_CLKS);
    chk(pushes == p0 + 1, "R6 single push while held low", pushes - p0, 1);
    chk(last_be && last_data == 8'h00 && !last_fe && !last_pe, "R5 break character",
        {last_be, last_fe, last_pe, 8'(last_data)}, 1024);
    drive(1'b1, 2 * BIT_CLKS);
    send_frame(8'h81, 8, 1'b1, exp_pbit(8'h81, 8, 1'b1, 1'b0), 1'b1);
    chk(pushes == p0 + 2 && last_data == 8'h81 && !last_be, "R6 resumes after mark",
        last_data, 8'h81);

    // R9 glitch
    par_en = 1'b0;
    p0 = pushes;
    drive(1'b0, 4);
    drive(1'b1, 3 * BIT_CLKS);
    chk(pushes == p0, "R9 glitch rejected", pushes - p0, 0);

    // R7 overrun
    send_frame(8'h5A, 8, 1'b0, 1'b0, 1'b1);
    p0 = pushes;
    fifo_full = 1'b1;
    send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b1);
    chk(pushes == p0, "R7 no push when full", pushes - p0, 0);
    chk(err_overrun == 1'b1, "R7 overrun set", err_overrun, 1);
    chk(push_data == 8'h5A, "R7 stored data untouched", push_data, 8'h5A);
    fifo_full = 1'b0;
    @(negedge clk);
    chk(err_overrun == 1'b0, "R7 overrun clears", err_overrun, 0);

    // R8 rx_en dropped mid-character
    p0 = pushes;
    fork
      send_frame(8'h96, 8, 1'b0, 1'b0, 1'b1);
      begin repeat (3 * BIT_CLKS) @(negedge clk); rx_en = 1'b0; end
    join
    chk(pushes == p0 + 1 && last_data == 8'h96, "R8 current char completes", last_data, 8'h96);
    p0 = pushes;
    send_frame(8'h0F, 8, 1'b0, 1'b0, 1'b1);
    chk(pushes == p0, "R8 disabled frame ignored", pushes - p0, 0);
    rx_en = 1'b1;

    // R10 loop-back with pin held low
    loop_sel = 1'b1;
    rx_pin = 1'b0;
    use_loop = 1'b1;
    p0 = pushes;
    send_frame(8'hC3, 8, 1'b0, 1'b0, 1'b1);
    chk(pushes == p0 + 1 && last_data == 8'hC3 && !last_be, "R10 loop-back source",
        last_data, 8'hC3);
    use_loop = 1'b0;
    rx_pin = 1'b1;
    repeat (4) @(negedge clk);
    loop_sel = 1'b0;

    summary();
    $finish;
  end
endmodule